// File: doc/BRIEF.md
# DAC waveform playback sequencer

The block replays a waveform held in an internal sample table into a byte-wide parallel DAC register port at a fixed sample rate. A prescaled auto-reload timer produces a sample tick. On each tick the sequencer fetches one 16-bit sample as two bytes, high byte first, and then performs four bus writes. The first write clears the DAC's update bit. The next two write the two halves of the code. The last write sets the update bit again, so the analog output moves to the new code in one step. The table pointer then advances, and it wraps at a programmable end index. For a 500-sample table that end index is 500.

The table is filled through a simple byte load port. A run input starts and stops playback. A stop always lets the sample in flight finish, and the next start begins again at table entry 0. If a tick arrives while a sample is still being written, the tick is dropped. A one-cycle overrun pulse marks the drop, and a saturating counter records it.

Top module: `wave_dac_player`

## Requirements
- R1: After reset the bus is idle (`dac_cs_n` = 1, `dac_we_n` = 1) and `ovr_count` is 0.
- R2: With `run` held high, new samples start every PRESCALE × (256 − `cfg_reload`) clocks. PRESCALE defaults to 12, so a reload of 0xFC gives one sample per 48 clocks.
- R3: Each sample is exactly four writes, in this order: address 3 data 0x01, address 1 high byte, address 0 low byte, address 3 data 0x05. In the control byte, bit 0 selects fast speed, bit 1 selects power-down and bit 2 enables the update. The update bit is off while the two data bytes are written.
- R4: For every write, `dac_cs_n` is low. `dac_we_n` is low for exactly 2 clocks. Address and data stay stable while `dac_we_n` is low and in the clock in which it returns high.
- R5: Sample i is stored at byte address 2i (high byte) and 2i+1 (low byte). The DAC code is {high[3:0], low}, and samples play in increasing index order.
- R6: After the sample at index `cfg_end` − 1, the next sample played is index 0.
- R7: A tick that arrives while a sample is being fetched or written is not queued. It raises `ovr_pulse` for one clock and increments `ovr_count`, which saturates at its maximum.
- R8: While `run` is low, no new sample starts. A sample already in progress completes, and the next sample after `run` returns high is index 0.
- R9: A byte presented on `ld_data` with `ld_en` high is written to table byte address `ld_addr` and is used by later playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Playback enable |
| cfg_reload | input | 8 | Timer reload value |
| cfg_end | input | 10 | Number of table entries played before wrapping |
| ld_en | input | 1 | Table load strobe |
| ld_addr | input | 10 | Table byte address for load |
| ld_data | input | 8 | Table byte to load |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_we_n | output | 1 | DAC write enable, active low |
| dac_addr | output | 2 | DAC register address |
| dac_data | output | 8 | DAC register data |
| ovr_pulse | output | 1 | One-clock flag for a dropped tick |
| ovr_count | output | 8 | Saturating count of dropped ticks |

## Verification
The sample tick and an unfinished four-write transaction can fall in the same cycle. Setting the reload to 0xFF makes the tick period 12 clocks, which is shorter than one transaction, so every second tick lands on a busy sequencer. The bench judges this in two ways. The DAC model must still see codes in strict table order with no repeats or skips. The overrun counter must equal the number of `ovr_pulse` clocks the monitor observed. A stop issued in the middle of a transaction is checked the same way: that sample must complete, and the restart must begin at entry 0.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RDHI  = 2'd1,
    SQ_RDLO  = 2'd2,
    SQ_WRITE = 2'd3
  } sq_state_e;

  localparam logic [1:0] REG_LO   = 2'd0;
  localparam logic [1:0] REG_HI   = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int CTL_FAST = 0;
  localparam int CTL_PDN  = 1;
  localparam int CTL_UPD  = 2;

  function automatic logic [7:0] ctl_word(input logic upd);
    logic [7:0] w;
    w = 8'h00;
    w[CTL_FAST] = 1'b1;
    w[CTL_PDN]  = 1'b0;
    w[CTL_UPD]  = upd;
    return w;
  endfunction
endpackage

// File: rtl/wdp_tick_gen.sv
module wdp_tick_gen #(
  parameter int PRESCALE = 12,
  parameter int TMR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMR_W-1:0] reload,
  output logic             tick
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             step;

  assign step = (pre_q == PRE_LAST);
  assign tick = run && step && (tmr_q == '1);

  always_comb begin
    pre_d = pre_q;
    tmr_d = tmr_q;
    if (!run) begin
      pre_d = '0;
      tmr_d = reload;
    end else begin
      pre_d = step ? '0 : pre_q + 1'b1;
      if (step) tmr_d = (tmr_q == '1) ? reload : tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else begin
      pre_q <= pre_d;
      tmr_q <= tmr_d;
    end
  end

  generate
    if (PRESCALE > 1) begin : g_gap_chk
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdp_sample_mem.sv
module wdp_sample_mem #(
  parameter int ABYTE_W = 10
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [ABYTE_W-1:0] wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  input  logic [ABYTE_W-1:0] rd_addr,
  output logic [7:0]         rd_data
);
  localparam int DEPTH_B = 1 << ABYTE_W;

  logic [7:0] mem [DEPTH_B];
  logic [7:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/wdp_bus_seq.sv
module wdp_bus_seq
  import wdp_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [IDX_W:0]   cfg_end,
  output logic             rd_en,
  output logic [IDX_W:0]   rd_addr,
  input  logic [7:0]       rd_data,
  output logic             busy,
  output logic             dac_cs_n,
  output logic             dac_we_n,
  output logic [1:0]       dac_addr,
  output logic [7:0]       dac_data
);
  sq_state_e        state_q, state_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [1:0]       wr_q, wr_d;
  logic [1:0]       ph_q, ph_d;
  logic [7:0]       hi_q, lo_q;
  logic             hi_en, lo_en;
  logic [IDX_W:0]   ptr_inc;
  logic             sample_done;

  assign ptr_inc     = {1'b0, ptr_q} + 1'b1;
  assign sample_done = (state_q == SQ_WRITE) && (wr_q == 2'd3) && (ph_q == 2'd3);
  assign busy        = (state_q != SQ_IDLE);
  assign hi_en       = (state_q == SQ_RDHI);
  assign lo_en       = (state_q == SQ_RDLO);
  assign rd_en       = ((state_q == SQ_IDLE) && tick) || (state_q == SQ_RDHI);
  assign rd_addr     = {ptr_q, (state_q == SQ_RDHI)};

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    wr_d    = wr_q;
    ph_d    = ph_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (!run) ptr_d = '0;
        else if (tick) state_d = SQ_RDHI;
      end
      SQ_RDHI: state_d = SQ_RDLO;
      SQ_RDLO: begin
        state_d = SQ_WRITE;
        wr_d    = 2'd0;
        ph_d    = 2'd0;
      end
      SQ_WRITE: begin
        ph_d = ph_q + 1'b1;
        if (ph_q == 2'd3) begin
          if (wr_q == 2'd3) begin
            state_d = SQ_IDLE;
            ptr_d   = (ptr_inc >= cfg_end) ? '0 : ptr_inc[IDX_W-1:0];
          end else begin
            wr_d = wr_q + 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ptr_q   <= '0;
      wr_q    <= '0;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      wr_q    <= wr_d;
      ph_q    <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= rd_data;
      if (lo_en) lo_q <= rd_data;
    end
  end

  always_comb begin
    dac_cs_n = 1'b1;
    dac_we_n = 1'b1;
    dac_addr = 2'd0;
    dac_data = 8'h00;
    if (state_q == SQ_WRITE) begin
      dac_cs_n = 1'b0;
      dac_we_n = !((ph_q == 2'd1) || (ph_q == 2'd2));
      unique case (wr_q)
        2'd0: begin dac_addr = REG_CTRL; dac_data = ctl_word(1'b0); end
        2'd1: begin dac_addr = REG_HI;   dac_data = hi_q;           end
        2'd2: begin dac_addr = REG_LO;   dac_data = lo_q;           end
        default: begin dac_addr = REG_CTRL; dac_data = ctl_word(1'b1); end
      endcase
    end
  end

  assert_we_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_we_n |-> !dac_cs_n);
  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_we_n) |=> !dac_we_n);
  assert_we_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_we_n) |-> ($stable(dac_addr) && $stable(dac_data)));
  assert_update_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> (($past(dac_addr) == REG_CTRL) &&
                         ($past(dac_data) == ctl_word(1'b1))));
  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_done |=> ((ptr_q == '0) || ({1'b0, ptr_q} < $past(cfg_end))));
endmodule

// File: rtl/wave_dac_player.sv
module wave_dac_player #(
  parameter int TABLE_DEPTH = 512,
  parameter int PRESCALE    = 12,
  parameter int TMR_W       = 8,
  parameter int OVR_W       = 8,
  parameter int IDX_W       = $clog2(TABLE_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMR_W-1:0] cfg_reload,
  input  logic [IDX_W:0]   cfg_end,
  input  logic             ld_en,
  input  logic [IDX_W:0]   ld_addr,
  input  logic [7:0]       ld_data,
  output logic             dac_cs_n,
  output logic             dac_we_n,
  output logic [1:0]       dac_addr,
  output logic [7:0]       dac_data,
  output logic             ovr_pulse,
  output logic [OVR_W-1:0] ovr_count
);
  logic [1:0]       rst_sync_q;
  logic             rst_sn;
  logic             tick;
  logic             seq_busy;
  logic             rd_en;
  logic [IDX_W:0]   rd_addr;
  logic [7:0]       rd_data;
  logic             ovr_en;
  logic [OVR_W-1:0] ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  wdp_tick_gen #(.PRESCALE(PRESCALE), .TMR_W(TMR_W)) u_tick (
    .clk(clk), .rst_n(rst_sn), .run(run), .reload(cfg_reload), .tick(tick)
  );

  wdp_sample_mem #(.ABYTE_W(IDX_W + 1)) u_mem (
    .clk(clk), .wr_en(ld_en), .wr_addr(ld_addr), .wr_data(ld_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  wdp_bus_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_sn), .run(run), .tick(tick), .cfg_end(cfg_end),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(seq_busy),
    .dac_cs_n(dac_cs_n), .dac_we_n(dac_we_n), .dac_addr(dac_addr),
    .dac_data(dac_data)
  );

  assign ovr_pulse = tick && seq_busy;
  assign ovr_en    = ovr_pulse && (ovr_q != '1);
  assign ovr_count = ovr_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     ovr_q <= '0;
    else if (ovr_en) ovr_q <= ovr_q + 1'b1;
  end

  assert_ovr_count_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (ovr_pulse && (ovr_count != '1)) |=> (ovr_count == $past(ovr_count) + 1'b1));
  assert_ovr_hold_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !ovr_pulse |=> $stable(ovr_count));
endmodule

// File: tb/test_wave_dac_player.sv
module test_wave_dac_player;
  localparam int CLK_PERIOD = 10;
  localparam int NSAMP      = 500;
  localparam int WD_LIMIT   = 120000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run;
  logic [7:0] cfg_reload;
  logic [9:0] cfg_end;
  logic       ld_en;
  logic [9:0] ld_addr;
  logic [7:0] ld_data;
  logic       dac_cs_n, dac_we_n, ovr_pulse;
  logic [1:0] dac_addr;
  logic [7:0] dac_data, ovr_count;

  wave_dac_player i_wave_dac_player (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_reload(cfg_reload),
    .cfg_end(cfg_end), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .dac_cs_n(dac_cs_n), .dac_we_n(dac_we_n), .dac_addr(dac_addr),
    .dac_data(dac_data), .ovr_pulse(ovr_pulse), .ovr_count(ovr_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  logic [7:0] tb_hi [NSAMP];
  logic [7:0] tb_lo [NSAMP];
  int exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected<%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // monitor / DAC register model
  bit         mon_on = 0;
  bit         per_chk = 0;
  int         per_exp = 48;
  int         last_start = 0;
  int         popped = 0;
  int         ovr_seen = 0;
  int         wpos = 0;
  logic       prev_we = 1'b1;
  logic [1:0] cap_a;
  logic [7:0] cap_d;
  int         low_len = 0;
  bit         stab_bad = 0;
  logic [7:0] m_hi = 0, m_lo = 0;
  bit         m_upd = 0;

  task automatic handle_write(input logic [1:0] a, input logic [7:0] d);
    int idx;
    idx = (exp_q.size() > 0) ? exp_q[0] : -1;
    case (wpos)
      0: begin
        check(a == 2'd3 && d == 8'h01, "R3 first write ctrl 0x01", {a, d}, {2'd3, 8'h01});
        if (per_chk && last_start > 0)
          check(cyc - last_start == per_exp, "R2 sample period", cyc - last_start, per_exp);
        last_start = cyc;
      end
      1: begin
        check(idx >= 0, "R8 unexpected sample", 0, 1);
        if (idx >= 0) check(a == 2'd1 && d == tb_hi[idx], "R3 R5 high byte write", {a, d}, {2'd1, tb_hi[idx]});
      end
      2: begin
        if (idx >= 0) check(a == 2'd0 && d == tb_lo[idx], "R3 R5 low byte write", {a, d}, {2'd0, tb_lo[idx]});
      end
      default: begin
        check(a == 2'd3 && d == 8'h05, "R3 last write ctrl 0x05", {a, d}, {2'd3, 8'h05});
      end
    endcase
    if (a == 2'd1 || a == 2'd0) begin
      check(!m_upd, "R3 data write while update on", 1, 0);
      if (a == 2'd1) m_hi = d; else m_lo = d;
    end
    if (a == 2'd3) begin
      m_upd = d[2];
      if (d[2] && exp_q.size() > 0) begin
        idx = exp_q.pop_front();
        popped++;
        check({m_hi[3:0], m_lo} == {tb_hi[idx][3:0], tb_lo[idx]},
              "R5 R6 R9 DAC code order", {m_hi[3:0], m_lo}, {tb_hi[idx][3:0], tb_lo[idx]});
      end else if (d[2]) begin
        check(0, "R8 update with no expected sample", {m_hi[3:0], m_lo}, 0);
      end
    end
    wpos = (wpos + 1) % 4;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (ovr_pulse) ovr_seen++;
      if (!dac_we_n) begin
        if (prev_we) begin
          cap_a = dac_addr; cap_d = dac_data; low_len = 1; stab_bad = 0;
          check(!dac_cs_n, "R4 cs low during write", dac_cs_n, 0);
        end else begin
          low_len++;
          if (dac_addr != cap_a || dac_data != cap_d) stab_bad = 1;
        end
      end else if (!prev_we) begin
        check(low_len == 2, "R4 write strobe width", low_len, 2);
        check(!stab_bad && dac_addr == cap_a && dac_data == cap_d && !dac_cs_n,
              "R4 address/data hold", {dac_addr, dac_data}, {cap_a, cap_d});
        handle_write(cap_a, cap_d);
      end
      prev_we = dac_we_n;
    end
  end

  task automatic push_run(input int first, input int n, input int endv);
    for (int k = 0; k < n; k++) exp_q.push_back((first + k) % endv);
  endtask

  task automatic load_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 10'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic stop_in_flight(input int target);
    while (popped < target) @(negedge clk);
    while (wpos != 1) @(negedge clk);
    run = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (150) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; cfg_reload = 8'hFC; cfg_end = 10'd500;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    for (int i = 0; i < NSAMP; i++) begin
      tb_hi[i] = 8'((i * 37) + 8'hA3);
      tb_lo[i] = 8'((i * 11) ^ 8'h3C);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(dac_cs_n == 1'b1, "R1 cs idle", dac_cs_n, 1);
    check(dac_we_n == 1'b1, "R1 we idle", dac_we_n, 1);
    check(ovr_count == 8'd0, "R1 overrun count", ovr_count, 0);

    // R9 table load through load port
    for (int i = 0; i < NSAMP; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 10'(2 * i); ld_data = tb_hi[i];
      @(negedge clk);
      ld_addr = 10'(2 * i + 1); ld_data = tb_lo[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    repeat (100) @(negedge clk);
    check(dac_cs_n == 1'b1, "R8 no writes while stopped", dac_cs_n, 1);
    mon_on = 1;

    // Phase A: full table, wrap at 500, period 48 clocks
    per_chk = 1; per_exp = 12 * (256 - 8'hFC);
    push_run(0, 504, 500);
    @(negedge clk); run = 1'b1;
    stop_in_flight(503);
    check(popped == 504, "R8 in-flight sample completes", popped, 504);
    check(dac_cs_n == 1'b1, "R8 bus idle after stop", dac_cs_n, 1);
    check(ovr_count == 8'd0, "R7 no overrun at long period", ovr_count, 0);

    // Phase B: short table, ticks faster than transactions
    per_chk = 0; last_start = 0;
    cfg_end = 10'd5; cfg_reload = 8'hFF;
    push_run(0, 12, 5);
    @(negedge clk); run = 1'b1;
    stop_in_flight(515);
    check(popped == 516, "R6 R8 short wrap completes", popped, 516);
    check(ovr_seen > 0, "R7 overrun observed", ovr_seen, 1);
    check(int'(ovr_count) == ovr_seen, "R7 overrun count matches pulses", ovr_count, ovr_seen);

    // Phase C: reload one byte, restart from index 0
    tb_lo[1] = 8'hEE;
    load_byte(3, 8'hEE);
    cfg_reload = 8'hFC;
    push_run(0, 3, 5);
    @(negedge clk); run = 1'b1;
    while (popped < 519) @(negedge clk);
    run = 1'b0;
    repeat (150) @(negedge clk);
    check(popped == 519 && exp_q.size() == 0, "R8 R9 restart at entry 0", popped, 519);
    check(dac_cs_n == 1'b1 && dac_we_n == 1'b1, "R8 idle at end", {dac_cs_n, dac_we_n}, 3);
    finish_run();
  end
endmodule